// File: doc/BRIEF.md
# Predicated Conditional-Move Unit

This unit sits in the execute stage and owns a small architectural state: a file of general registers and a file of one-bit predicate registers. Each accepted instruction arrives already decoded as an opcode, register indices, predicate indices, a guard predicate index and an immediate, qualified by a valid strobe. The unit reads its operands, decides whether the instruction has any effect, and retires it one cycle later.

Two kinds of conditional execution are supported. A conditional move copies a source register to a destination only when a test register is zero, or only when it is nonzero. A compare writes a complementary pair of predicates from an equality test. Every instruction is also guarded by a predicate. When that guard is false the instruction still takes its slot and still signals completion, but it changes no register and no predicate. Back-to-back dependent instructions see each other's results through bypass paths, so software never has to insert bubbles.

Top module: `pcm_unit`

## Requirements
- R1: `done_o` is high in exactly the cycle after each cycle with `in_valid` high, whatever the guard or opcode, and low otherwise.
- R2: Opcode 2 (move-if-zero) writes the `in_rs` value into `in_rd` when the `in_rt` value is zero and the guard is true, and writes nothing otherwise.
- R3: Opcode 3 (move-if-nonzero) writes the `in_rs` value into `in_rd` when the `in_rt` value is nonzero and the guard is true, and writes nothing otherwise.
- R4: Opcode 4 (compare-equal), when its guard is true, sets predicate `in_pa` and clears predicate `in_pb` if the `in_rs` and `in_rt` values are equal, and does the opposite otherwise; it never writes a general register; if `in_pa` equals `in_pb` that predicate takes the equality result.
- R5: When the predicate selected by `in_guard` is false, the instruction writes no general register and no predicate.
- R6: Opcode 0 loads `in_imm` into `in_rd`, and opcode 1 copies the `in_rs` value into `in_rd`, each when the guard is true.
- R7: Register 0 always reads as zero; a write to it is dropped and `wr_o` stays low.
- R8: Predicate 0 always reads as one; a compare that targets it leaves it at one.
- R9: An instruction issued in the cycle right after another sees that instruction's register and predicate results in its operands and its guard.
- R10: After reset every general register reads zero, `pred_o` is 8'h01 and `done_o` is low.
- R11: Opcodes 5, 6 and 7 complete like any other instruction but change no register and no predicate.
- R12: In the completion cycle `wr_o`, `wr_idx_o` and `wr_data_o` report the register write performed, `src_a_o` and `src_b_o` show the `in_rs` and `in_rt` operand values read, and `pred_o` shows all predicates as updated by every earlier instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode: 0 load-immediate, 1 move, 2 move-if-zero, 3 move-if-nonzero, 4 compare-equal |
| in_rd | input | 5 | Destination register index |
| in_rs | input | 5 | First source register index |
| in_rt | input | 5 | Second source (test) register index |
| in_guard | input | 3 | Index of the predicate guarding the instruction |
| in_pa | input | 3 | Predicate written with the equality result |
| in_pb | input | 3 | Predicate written with its complement |
| in_imm | input | 32 | Immediate for load-immediate |
| done_o | output | 1 | Instruction completed |
| wr_o | output | 1 | A general register was written |
| wr_idx_o | output | 5 | Index of the written register |
| wr_data_o | output | 32 | Value written |
| src_a_o | output | 32 | First operand value read |
| src_b_o | output | 32 | Second operand value read |
| pred_o | output | 8 | Current predicate file |

## Verification
The bench drives dependent pairs in adjacent cycles, because a design without forwarding would hand the second instruction a stale operand or a stale guard and the copied value or the suppression decision would come out wrong. It aims compares at predicate 0 and at a single predicate named twice, where a design that let the complement write win, or let predicate 0 be cleared, would then suppress every unguarded instruction. Writes to register 0, false guards on every opcode and the unused opcodes are mixed into a long random stream; a design that let any of them leak would show a register or predicate change in a later operand read, and one that tied completion to the guard would drop a done pulse.

// File: rtl/pcm_pkg.sv
// Package: opcode encoding shared by the conditional-move unit and its checker.
// Assumes a three-bit opcode field; values 5 to 7 are reserved and inert.
package pcm_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LDI   = 3'd0,
        OP_MOV   = 3'd1,
        OP_CMOVZ = 3'd2,
        OP_CMOVN = 3'd3,
        OP_CMPEQ = 3'd4
    } op_e;

endpackage

// File: rtl/pcm_gpr_file.sv
// General register file with NRD read ports and one write port.
// Entry 0 is constant zero. A read of the index being written this cycle
// returns the incoming data, so a consumer one cycle behind a producer
// sees the new value. Assumes synchronous active-low reset clears all entries.
module pcm_gpr_file #(
    parameter int DW   = 32,
    parameter int NREG = 32,
    parameter int NRD  = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);

    logic [DW-1:0] mem [NREG];

    // Storage update: clear on reset, otherwise commit the write (entry 0 never).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Read port p: zero for entry 0, bypassed write data, else stored value.
        always_comb begin
            if (raddr[p] == '0) begin
                rdata[p] = '0;
            end else if (we && (waddr == raddr[p])) begin
                rdata[p] = wdata;
            end else begin
                rdata[p] = mem[raddr[p]];
            end
        end
    end

endmodule

// File: rtl/pcm_pred_file.sv
// Predicate file of NPRED one-bit entries with two write ports.
// Entry 0 is constant one. Port A overrides port B on the same index.
// The guard read sees this cycle's writes (bypass). pred_vec is the committed state.
module pcm_pred_file #(
    parameter int NPRED = 8,
    localparam int PW   = $clog2(NPRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_a,
    input  logic [PW-1:0]    idx_a,
    input  logic             val_a,
    input  logic             we_b,
    input  logic [PW-1:0]    idx_b,
    input  logic             val_b,
    input  logic [PW-1:0]    guard_idx,
    output logic             guard_val,
    output logic [NPRED-1:0] pred_vec
);

    logic [NPRED-1:0] cur_q;
    logic [NPRED-1:0] nxt;

    // Next state: apply port B, then port A so A wins, then pin entry 0 high.
    always_comb begin
        nxt = cur_q;
        if (we_b) begin
            nxt[idx_b] = val_b;
        end
        if (we_a) begin
            nxt[idx_a] = val_a;
        end
        nxt[0] = 1'b1;
    end

    // State register: reset to only entry 0 true.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= {{(NPRED-1){1'b0}}, 1'b1};
        end else begin
            cur_q <= nxt;
        end
    end

    assign guard_val = nxt[guard_idx];
    assign pred_vec  = cur_q;

endmodule

// File: rtl/pcm_exec.sv
// Combinational decision logic: given operands and the guard value, produce
// the register write and predicate writes for one instruction.
// Assumes operands are already bypassed. Reserved opcodes produce no writes.
module pcm_exec
    import pcm_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 32,
    parameter int NPRED = 8,
    localparam int AW   = $clog2(NREG),
    localparam int PW   = $clog2(NPRED)
) (
    input  op_e           op,
    input  logic          guard_ok,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] imm,
    input  logic [AW-1:0] rd,
    input  logic [PW-1:0] pa,
    input  logic [PW-1:0] pb,
    output logic          rf_we,
    output logic [DW-1:0] rf_wdata,
    output logic          pr_we_a,
    output logic [PW-1:0] pr_idx_a,
    output logic          pr_val_a,
    output logic          pr_we_b,
    output logic [PW-1:0] pr_idx_b,
    output logic          pr_val_b
);

    logic same;
    logic want_wr;

    assign same     = (opnd_a == opnd_b);
    assign pr_idx_a = pa;
    assign pr_idx_b = pb;
    assign pr_val_a = same;
    assign pr_val_b = !same;

    // Opcode decode: decide the candidate write and its data.
    always_comb begin
        want_wr  = 1'b0;
        rf_wdata = '0;
        pr_we_a  = 1'b0;
        pr_we_b  = 1'b0;
        case (op)
            OP_LDI: begin
                want_wr  = guard_ok;
                rf_wdata = imm;
            end
            OP_MOV: begin
                want_wr  = guard_ok;
                rf_wdata = opnd_a;
            end
            OP_CMOVZ: begin
                want_wr  = guard_ok && (opnd_b == '0);
                rf_wdata = opnd_a;
            end
            OP_CMOVN: begin
                want_wr  = guard_ok && (opnd_b != '0);
                rf_wdata = opnd_a;
            end
            OP_CMPEQ: begin
                pr_we_a = guard_ok;
                pr_we_b = guard_ok;
            end
            default: begin
                want_wr = 1'b0;
            end
        endcase
    end

    assign rf_we = want_wr && (rd != '0);

endmodule

// File: rtl/pcm_unit.sv
// Top of the predicated conditional-move unit.
// One stage: operands and guard are read (with bypass) in the issue cycle,
// the outcome is registered, and the registered write commits at the end of
// the completion cycle while done_o is high. Assumes in_* are stable around
// the clock edge and that reset is synchronous and active low.
module pcm_unit
    import pcm_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 32,
    parameter int NPRED = 8,
    localparam int AW   = $clog2(NREG),
    localparam int PW   = $clog2(NPRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_op,
    input  logic [AW-1:0]    in_rd,
    input  logic [AW-1:0]    in_rs,
    input  logic [AW-1:0]    in_rt,
    input  logic [PW-1:0]    in_guard,
    input  logic [PW-1:0]    in_pa,
    input  logic [PW-1:0]    in_pb,
    input  logic [DW-1:0]    in_imm,
    output logic             done_o,
    output logic             wr_o,
    output logic [AW-1:0]    wr_idx_o,
    output logic [DW-1:0]    wr_data_o,
    output logic [DW-1:0]    src_a_o,
    output logic [DW-1:0]    src_b_o,
    output logic [NPRED-1:0] pred_o
);

    // Completion-stage state
    logic          st_done;
    logic          st_rf_we;
    logic [AW-1:0] st_rd;
    logic [DW-1:0] st_wdata;
    logic [DW-1:0] st_a;
    logic [DW-1:0] st_b;
    logic          st_pwe_a;
    logic [PW-1:0] st_pidx_a;
    logic          st_pval_a;
    logic          st_pwe_b;
    logic [PW-1:0] st_pidx_b;
    logic          st_pval_b;

    // Issue-side signals
    logic [AW-1:0] rd_addr [2];
    logic [DW-1:0] rd_data [2];
    logic          guard_ok;
    logic          ex_rf_we;
    logic [DW-1:0] ex_wdata;
    logic          ex_pwe_a;
    logic [PW-1:0] ex_pidx_a;
    logic          ex_pval_a;
    logic          ex_pwe_b;
    logic [PW-1:0] ex_pidx_b;
    logic          ex_pval_b;

    assign rd_addr[0] = in_rs;
    assign rd_addr[1] = in_rt;

    pcm_gpr_file #(
        .DW   (DW),
        .NREG (NREG),
        .NRD  (2)
    ) gpr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_done && st_rf_we),
        .waddr (st_rd),
        .wdata (st_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    pcm_pred_file #(
        .NPRED (NPRED)
    ) pred_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_a      (st_done && st_pwe_a),
        .idx_a     (st_pidx_a),
        .val_a     (st_pval_a),
        .we_b      (st_done && st_pwe_b),
        .idx_b     (st_pidx_b),
        .val_b     (st_pval_b),
        .guard_idx (in_guard),
        .guard_val (guard_ok),
        .pred_vec  (pred_o)
    );

    pcm_exec #(
        .DW    (DW),
        .NREG  (NREG),
        .NPRED (NPRED)
    ) exec_i (
        .op       (op_e'(in_op)),
        .guard_ok (guard_ok),
        .opnd_a   (rd_data[0]),
        .opnd_b   (rd_data[1]),
        .imm      (in_imm),
        .rd       (in_rd),
        .pa       (in_pa),
        .pb       (in_pb),
        .rf_we    (ex_rf_we),
        .rf_wdata (ex_wdata),
        .pr_we_a  (ex_pwe_a),
        .pr_idx_a (ex_pidx_a),
        .pr_val_a (ex_pval_a),
        .pr_we_b  (ex_pwe_b),
        .pr_idx_b (ex_pidx_b),
        .pr_val_b (ex_pval_b)
    );

    // Completion stage: done and write-enables follow valid; payload loads on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done   <= 1'b0;
            st_rf_we  <= 1'b0;
            st_pwe_a  <= 1'b0;
            st_pwe_b  <= 1'b0;
            st_rd     <= '0;
            st_wdata  <= '0;
            st_a      <= '0;
            st_b      <= '0;
            st_pidx_a <= '0;
            st_pval_a <= 1'b0;
            st_pidx_b <= '0;
            st_pval_b <= 1'b0;
        end else begin
            st_done  <= in_valid;
            st_rf_we <= in_valid && ex_rf_we;
            st_pwe_a <= in_valid && ex_pwe_a;
            st_pwe_b <= in_valid && ex_pwe_b;
            if (in_valid) begin
                st_rd     <= in_rd;
                st_wdata  <= ex_wdata;
                st_a      <= rd_data[0];
                st_b      <= rd_data[1];
                st_pidx_a <= ex_pidx_a;
                st_pval_a <= ex_pval_a;
                st_pidx_b <= ex_pidx_b;
                st_pval_b <= ex_pval_b;
            end
        end
    end

    assign done_o    = st_done;
    assign wr_o      = st_done && st_rf_we;
    assign wr_idx_o  = st_rd;
    assign wr_data_o = st_wdata;
    assign src_a_o   = st_a;
    assign src_b_o   = st_b;

endmodule

// File: rtl/pcm_unit_chk.sv
// Checker for pcm_unit: port-level timing and effect properties.
// Assumes the opcode encoding of pcm_pkg. Bound to every pcm_unit instance.
module pcm_unit_chk
    import pcm_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 32,
    parameter int NPRED = 8,
    localparam int AW   = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  in_op,
    input logic             done_o,
    input logic             wr_o,
    input logic [AW-1:0]    wr_idx_o,
    input logic [DW-1:0]    wr_data_o,
    input logic [DW-1:0]    src_a_o,
    input logic [DW-1:0]    src_b_o,
    input logic [NPRED-1:0] pred_o
);

    p_done_after_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done_o);

    p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done_o);

    p_write_only_on_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> done_o);

    p_zero_reg_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (wr_idx_o != '0));

    p_pred_zero_true_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pred_o[0]);

    p_cmovz_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ($past(in_op) == OP_CMOVZ) && (src_b_o != '0)) |-> !wr_o);

    p_cmovn_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ($past(in_op) == OP_CMOVN) && (src_b_o == '0)) |-> !wr_o);

    p_move_copies_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && (($past(in_op) == OP_MOV) || ($past(in_op) == OP_CMOVZ)
                  || ($past(in_op) == OP_CMOVN))) |-> (wr_data_o == src_a_o));

    p_compare_no_reg_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ($past(in_op) == OP_CMPEQ)) |-> !wr_o);

    p_reserved_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ($past(in_op) > OP_CMPEQ)) |-> !wr_o);

    p_pred_change_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pred_o) |-> $past(done_o));

endmodule

bind pcm_unit pcm_unit_chk #(
    .DW    (DW),
    .NREG  (NREG),
    .NPRED (NPRED)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .done_o    (done_o),
    .wr_o      (wr_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o),
    .src_a_o   (src_a_o),
    .src_b_o   (src_b_o),
    .pred_o    (pred_o)
);

// File: tb/pcm_unit_tb_top.sv
// Bench for pcm_unit: a behavioural model (arrays updated in program order)
// predicts every completion cycle; outputs are compared at each falling edge.
module pcm_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [4:0]  in_rd;
    logic [4:0]  in_rs;
    logic [4:0]  in_rt;
    logic [2:0]  in_guard;
    logic [2:0]  in_pa;
    logic [2:0]  in_pb;
    logic [31:0] in_imm;
    logic        done_o;
    logic        wr_o;
    logic [4:0]  wr_idx_o;
    logic [31:0] wr_data_o;
    logic [31:0] src_a_o;
    logic [31:0] src_b_o;
    logic [7:0]  pred_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_rd     (in_rd),
        .in_rs     (in_rs),
        .in_rt     (in_rt),
        .in_guard  (in_guard),
        .in_pa     (in_pa),
        .in_pb     (in_pb),
        .in_imm    (in_imm),
        .done_o    (done_o),
        .wr_o      (wr_o),
        .wr_idx_o  (wr_idx_o),
        .wr_data_o (wr_data_o),
        .src_a_o   (src_a_o),
        .src_b_o   (src_b_o),
        .pred_o    (pred_o)
    );

    // Reference state and pending expectation
    logic [31:0] m_regs [32];
    logic [7:0]  m_preds;
    bit          e_pend;
    bit          e_wr;
    logic [4:0]  e_idx;
    logic [31:0] e_data;
    logic [31:0] e_a;
    logic [31:0] e_b;
    logic [7:0]  e_pred;
    string       e_tag;
    int          vectors = 0;
    int          misses  = 0;
    bit          finished = 0;

    task automatic miss(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        misses++;
        $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    endtask

    // Compare the current completion cycle against the pending expectation.
    task automatic check_cycle();
        vectors++;
        if (done_o !== e_pend) miss("R1", "done_o", 32'(done_o), 32'(e_pend));
        if (e_pend) begin
            if (wr_o !== e_wr) miss(e_tag, "wr_o", 32'(wr_o), 32'(e_wr));
            if (e_wr && (wr_idx_o !== e_idx))
                miss(e_tag, "wr_idx_o", 32'(wr_idx_o), 32'(e_idx));
            if (e_wr && (wr_data_o !== e_data))
                miss(e_tag, "wr_data_o", wr_data_o, e_data);
            if (src_a_o !== e_a) miss(e_tag, "src_a_o", src_a_o, e_a);
            if (src_b_o !== e_b) miss(e_tag, "src_b_o", src_b_o, e_b);
            if (pred_o !== e_pred) miss(e_tag, "pred_o", 32'(pred_o), 32'(e_pred));
        end
    endtask

    // Issue one instruction and predict its completion from the model.
    task automatic issue(input int op, input int rd, input int rs, input int rt,
                         input int g, input int pa, input int pb,
                         input logic [31:0] imm, input string tag);
        logic [31:0] a;
        logic [31:0] b;
        logic        gv;
        logic        eq;
        @(negedge clk);
        check_cycle();
        in_valid = 1'b1;
        in_op    = 3'(op);
        in_rd    = 5'(rd);
        in_rs    = 5'(rs);
        in_rt    = 5'(rt);
        in_guard = 3'(g);
        in_pa    = 3'(pa);
        in_pb    = 3'(pb);
        in_imm   = imm;
        a  = m_regs[rs];
        b  = m_regs[rt];
        gv = m_preds[g];
        e_pend = 1;
        e_pred = m_preds;
        e_a    = a;
        e_b    = b;
        e_wr   = 0;
        e_data = '0;
        e_idx  = 5'(rd);
        e_tag  = tag;
        case (op)
            0: begin e_wr = gv; e_data = imm; end
            1: begin e_wr = gv; e_data = a; end
            2: begin e_wr = gv && (b == 0); e_data = a; end
            3: begin e_wr = gv && (b != 0); e_data = a; end
            4: if (gv) begin
                eq = (a == b);
                if (pb != 0) m_preds[pb] = !eq;
                if (pa != 0) m_preds[pa] = eq;
            end
            default: e_wr = 0;
        endcase
        if (rd == 0) e_wr = 0;
        if (e_wr) m_regs[rd] = e_data;
    endtask

    task automatic idle();
        @(negedge clk);
        check_cycle();
        in_valid = 1'b0;
        e_pend   = 0;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_regs[i] = '0;
        m_preds  = 8'h01;
        e_pend   = 0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_op = '0; in_rd = '0; in_rs = '0; in_rt = '0;
        in_guard = '0; in_pa = '0; in_pb = '0; in_imm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state at the ports
        vectors++;
        if (done_o !== 1'b0) miss("R10", "done_o", 32'(done_o), 32'd0);
        if (pred_o !== 8'h01) miss("R10", "pred_o", 32'(pred_o), 32'h01);

        // R10 / R11: read every register through reserved opcodes
        for (int i = 0; i < 32; i++) issue(5 + (i % 3), i, i, 31 - i, 0, 1, 2, 32'hFFFF_FFFF, "R10");

        // R6: load immediates and a plain move
        for (int i = 1; i <= 8; i++) issue(0, i, 0, 0, 0, 0, 0, 32'h1000_0000 * i + i, "R6");
        issue(1, 9, 1, 0, 0, 0, 0, '0, "R6");
        // R9: dependent pair in adjacent cycles
        issue(0, 10, 0, 0, 0, 0, 0, 32'hCAFE_0010, "R9");
        issue(1, 11, 10, 10, 0, 0, 0, '0, "R9");
        // R2: move-if-zero with zero and nonzero test
        issue(2, 12, 1, 0, 0, 0, 0, '0, "R2");
        issue(2, 13, 2, 3, 0, 0, 0, '0, "R2");
        // R3: move-if-nonzero with nonzero and zero test
        issue(3, 14, 4, 5, 0, 0, 0, '0, "R3");
        issue(3, 15, 4, 0, 0, 0, 0, '0, "R3");
        // R4: equal compare, then R5 / R9 guards on the fresh predicates
        issue(4, 0, 1, 1, 0, 1, 2, '0, "R4");
        issue(0, 16, 0, 0, 2, 0, 0, 32'hDEAD_0016, "R5");
        issue(0, 17, 0, 0, 1, 0, 0, 32'hBEEF_0017, "R9");
        issue(4, 0, 1, 2, 0, 3, 4, '0, "R4");
        issue(2, 18, 5, 0, 3, 0, 0, '0, "R5");
        issue(4, 0, 6, 6, 0, 5, 5, '0, "R4");
        issue(4, 0, 6, 7, 0, 6, 6, '0, "R4");
        // R8: compare aimed at predicate 0 both as set and clear target
        issue(4, 0, 1, 2, 0, 0, 7, '0, "R8");
        issue(4, 0, 1, 1, 0, 7, 0, '0, "R8");
        issue(0, 19, 0, 0, 0, 0, 0, 32'h0000_0019, "R8");
        // R5: false-guard compare leaves predicates alone
        issue(4, 0, 1, 1, 3, 3, 4, '0, "R5");
        issue(1, 0, 0, 0, 0, 0, 0, '0, "R5");
        // R7: write to register 0 then read it back-to-back
        issue(0, 0, 0, 0, 0, 0, 0, 32'h5555_AAAA, "R7");
        issue(1, 20, 0, 0, 0, 0, 0, '0, "R7");
        // R11: reserved opcodes with a true guard
        issue(5, 21, 1, 2, 0, 1, 2, 32'h1, "R11");
        issue(6, 22, 3, 4, 0, 3, 4, 32'h2, "R11");
        issue(7, 23, 5, 6, 0, 5, 6, 32'h3, "R11");
        issue(1, 0, 21, 22, 0, 0, 0, '0, "R11");
        // R1: gaps with no instruction
        idle();
        idle();
        idle();

        // R12: long mixed stream with random gaps
        for (int n = 0; n < 2000; n++) begin
            if ($urandom_range(0, 4) == 0) begin
                idle();
            end else begin
                issue($urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 15),
                      $urandom_range(0, 15), $urandom_range(0, 7), $urandom_range(0, 7),
                      $urandom_range(0, 7),
                      ($urandom_range(0, 3) == 0) ? 32'h0 : 32'($urandom), "R12");
            end
        end
        idle();
        idle();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule